// File: doc/BRIEF.md
# Shared Thread-List and Instruction-Line Array

This block keeps one physical array of entries that each serve one of two roles. In cache role an entry is an ordinary instruction line with a tag. In scheduler role it holds a thread: the instruction line the thread is executing, a finger that gives the exact program counter inside that line, a context number, a blocker queue number and a link to the next runnable entry. A mode bit per entry selects the role. The cache port compares tags across all entries. Entries in scheduler role never report a hit. A cache line becomes a thread entry when a thread is spawned into it, and it goes back to being an empty cache line when the thread is freed.

Thread entries sit in one of three pools: ready (linked in a single runnable list, served first in first out), active (handed to the work window) and stalled (waiting on data). A thread returned from the work window with a data stall goes to the stalled pool and records the queue it waits on. A thread returned with a structural stall is put at the tail of the runnable list. A wake command carries a context and a queue number. It promotes the matching stalled entry to the runnable tail. Any link may carry a spill mark. When the marked entry leaves the head, the next issue request reports a trap instead of returning a thread, and the request after that continues along the list.

Scheduler commands go through a two-state controller. In IDLE a command runs in the cycle it arrives if the cache port is quiet. If the cache port is busy in that cycle, the command is latched and the controller moves to HOLD (IDLE→HOLD). HOLD runs the latched command in the first cycle the cache port is quiet (HOLD→IDLE), and stays in HOLD while the cache port stays busy (HOLD→HOLD).

Top module: `sched_icache_array`

## Requirements
- R1: After reset every lookup misses, an issue command answers ok=0, and `op_ready` is 1.
- R2: A lookup hits only on an entry that is valid, in cache role and has an equal tag. When several entries match, the lowest index is reported. Hit, index and line appear on the cycle after the request.
- R3: A line fill writes tag and line and marks the entry valid only if the entry is in cache role. A fill aimed at a scheduler entry is ignored.
- R4: Command code 1 (spawn) succeeds only on a cache-role entry. It takes the entry out of the cache, loads line, finger and context, and appends the entry to the runnable tail. A spawn on a scheduler entry answers ok=0.
- R5: Command code 2 (issue) removes the runnable head and returns its index, context, finger and line. Issue order is append order. With an empty list and no pending trap, it answers ok=0.
- R6: Command code 3 (data stall) moves an active entry to the stalled pool with the given queue number and finger. A stalled entry is not issued again until it is woken.
- R7: Command code 4 (structural stall) appends an active entry to the runnable tail with the given finger.
- R8: Command code 5 (wake) promotes the lowest-index stalled entry whose context and blocker queue both equal the command's values, appends it to the tail and returns its index. It answers ok=0 when no entry matches.
- R9: Command code 6 (spill mark) sets the mark on a scheduler entry. After that entry is issued, the next issue answers ok=1, trap=1 and removes nothing. Appending an entry clears its mark.
- R10: Command code 7 (free) turns an active entry back into an invalid cache line that later fills can use.
- R11: While the cache port (lookup or fill) is active, no scheduler command runs. The response comes one cycle after the first quiet cycle.
- R12: A command aimed at an entry in the wrong pool, and the unused code 0, answer ok=0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Cache lookup request |
| lk_tag | input | TAG_W | Lookup tag |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_idx | output | IDX_W | Index of hitting entry |
| lk_line | output | LINE_W | Line of hitting entry |
| fill_en | input | 1 | Line fill write |
| fill_idx | input | IDX_W | Fill target entry |
| fill_tag | input | TAG_W | Fill tag |
| fill_line | input | LINE_W | Fill data |
| op_valid | input | 1 | Scheduler command present |
| op_code | input | 3 | Command code (1 spawn, 2 issue, 3 data stall, 4 structural stall, 5 wake, 6 spill mark, 7 free) |
| op_idx | input | IDX_W | Target entry |
| op_ctx | input | CTX_W | Context number |
| op_qid | input | QID_W | Queue number |
| op_finger | input | FIN_W | Finger (program counter within line) |
| op_line | input | LINE_W | Instruction line for spawn |
| op_ready | output | 1 | Controller in IDLE, accepts a command |
| rsp_valid | output | 1 | Command result present |
| rsp_ok | output | 1 | Command took effect |
| rsp_trap | output | 1 | Issue met a spill mark |
| rsp_idx | output | IDX_W | Entry acted on |
| rsp_ctx | output | CTX_W | Issued context |
| rsp_finger | output | FIN_W | Issued finger |
| rsp_line | output | LINE_W | Issued line |

## Verification
Lookup results are due exactly one cycle after the request. A command offered with the cache port quiet answers one cycle after it is offered. A command that collides with a cache access answers two cycles after it is offered, and in the cycle between, rsp_valid must be 0. The bench drives on the falling edge and samples on the falling edge that follows each rising edge. For a collided command it checks that the response is absent on the first falling edge and present on the second. A bench model predicts every result: a queue of runnable indices, per-entry pools and a pending trap flag.

// File: rtl/sil_pkg.sv
package sil_pkg;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_SPAWN      = 3'd1,
        OP_ISSUE      = 3'd2,
        OP_BLK_DATA   = 3'd3,
        OP_BLK_STRUCT = 3'd4,
        OP_WAKE       = 3'd5,
        OP_SPILL      = 3'd6,
        OP_FREE       = 3'd7
    } sil_op_e;

    typedef enum logic [1:0] {
        P_CACHE  = 2'd0,
        P_READY  = 2'd1,
        P_ACTIVE = 2'd2,
        P_STALL  = 2'd3
    } sil_pool_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } sil_fsm_e;

endpackage

// File: rtl/sil_first_set.sv
module sil_first_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest set index wins
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sil_tag_match.sv
module sil_tag_match #(
    parameter int N  = 8,
    parameter int IW = 3,
    parameter int TW = 12
) (
    input  logic [N-1:0]  valid_mask,
    input  logic [N-1:0]  sched_mask,
    input  logic [TW-1:0] tags [N],
    input  logic [TW-1:0] key,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);
    logic [N-1:0] match;

    // the sched mode bit gates each comparator output
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid_mask[g] & ~sched_mask[g] & (tags[g] == key);
    end

    sil_first_set #(.N(N), .IW(IW)) u_pick (
        .vec (match),
        .any (hit),
        .idx (hit_idx)
    );
endmodule

// File: rtl/sil_wake_match.sv
module sil_wake_match #(
    parameter int N  = 8,
    parameter int IW = 3,
    parameter int CW = 6,
    parameter int QW = 4
) (
    input  logic [N-1:0]  stall_mask,
    input  logic [CW-1:0] ctxs [N],
    input  logic [QW-1:0] blks [N],
    input  logic [CW-1:0] key_ctx,
    input  logic [QW-1:0] key_qid,
    output logic          found,
    output logic [IW-1:0] found_idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = stall_mask[g] & (ctxs[g] == key_ctx) & (blks[g] == key_qid);
    end

    sil_first_set #(.N(N), .IW(IW)) u_pick (
        .vec (match),
        .any (found),
        .idx (found_idx)
    );
endmodule

// File: rtl/sched_icache_array.sv
module sched_icache_array
    import sil_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 32,
    parameter int TAG_W   = 12,
    parameter int CTX_W   = 6,
    parameter int QID_W   = 4,
    parameter int FIN_W   = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [LINE_W-1:0] lk_line,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [CTX_W-1:0]  op_ctx,
    input  logic [QID_W-1:0]  op_qid,
    input  logic [FIN_W-1:0]  op_finger,
    input  logic [LINE_W-1:0] op_line,
    output logic              op_ready,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_trap,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [CTX_W-1:0]  rsp_ctx,
    output logic [FIN_W-1:0]  rsp_finger,
    output logic [LINE_W-1:0] rsp_line
);

    // ---------------- storage ----------------
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] nxt_v_q;
    logic [ENTRIES-1:0] trp_q;
    sil_pool_e          pool_q [ENTRIES];
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [LINE_W-1:0]  line_q [ENTRIES];
    logic [CTX_W-1:0]   ctx_q  [ENTRIES];
    logic [FIN_W-1:0]   fin_q  [ENTRIES];
    logic [QID_W-1:0]   blk_q  [ENTRIES];
    logic [IDX_W-1:0]   nxt_q  [ENTRIES];

    logic [IDX_W-1:0]   head_q, tail_q;
    logic               head_v_q, head_trap_q;

    sil_fsm_e           state_q, state_d;

    sil_op_e            pend_op;
    logic [IDX_W-1:0]   pend_idx;
    logic [CTX_W-1:0]   pend_ctx;
    logic [QID_W-1:0]   pend_qid;
    logic [FIN_W-1:0]   pend_fin;
    logic [LINE_W-1:0]  pend_line;

    // ---------------- per-entry masks ----------------
    logic [ENTRIES-1:0] sched_mask, stall_mask, ready_mask;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_mask
        assign sched_mask[g] = (pool_q[g] != P_CACHE);
        assign stall_mask[g] = (pool_q[g] == P_STALL);
        assign ready_mask[g] = (pool_q[g] == P_READY);
    end

    // ---------------- match units ----------------
    logic             tm_hit;
    logic [IDX_W-1:0] tm_idx;
    logic             wk_found;
    logic [IDX_W-1:0] wk_idx;

    sil_op_e           cur_op;
    logic [IDX_W-1:0]  cur_idx;
    logic [CTX_W-1:0]  cur_ctx;
    logic [QID_W-1:0]  cur_qid;
    logic [FIN_W-1:0]  cur_fin;
    logic [LINE_W-1:0] cur_line;

    sil_tag_match #(.N(ENTRIES), .IW(IDX_W), .TW(TAG_W)) u_tag (
        .valid_mask (valid_q),
        .sched_mask (sched_mask),
        .tags       (tag_q),
        .key        (lk_tag),
        .hit        (tm_hit),
        .hit_idx    (tm_idx)
    );

    sil_wake_match #(.N(ENTRIES), .IW(IDX_W), .CW(CTX_W), .QW(QID_W)) u_wake (
        .stall_mask (stall_mask),
        .ctxs       (ctx_q),
        .blks       (blk_q),
        .key_ctx    (cur_ctx),
        .key_qid    (cur_qid),
        .found      (wk_found),
        .found_idx  (wk_idx)
    );

    // ---------------- command decode ----------------
    logic             cache_busy;
    logic             exec;
    logic             ok, trap, pop, app;
    logic [IDX_W-1:0] app_idx, tgt;

    assign cache_busy = lk_req | fill_en;
    assign op_ready   = (state_q == S_IDLE);

    always_comb begin
        if (state_q == S_HOLD) begin
            cur_op   = pend_op;
            cur_idx  = pend_idx;
            cur_ctx  = pend_ctx;
            cur_qid  = pend_qid;
            cur_fin  = pend_fin;
            cur_line = pend_line;
            exec     = !cache_busy;
        end else begin
            cur_op   = sil_op_e'(op_code);
            cur_idx  = op_idx;
            cur_ctx  = op_ctx;
            cur_qid  = op_qid;
            cur_fin  = op_finger;
            cur_line = op_line;
            exec     = op_valid && !cache_busy;
        end
    end

    always_comb begin
        ok      = 1'b0;
        trap    = 1'b0;
        pop     = 1'b0;
        app     = 1'b0;
        app_idx = cur_idx;
        tgt     = cur_idx;
        unique case (cur_op)
            OP_NONE: ok = 1'b0;
            OP_SPAWN: begin
                ok  = (pool_q[cur_idx] == P_CACHE);
                app = 1'b1;
            end
            OP_ISSUE: begin
                ok   = head_trap_q | head_v_q;
                trap = head_trap_q;
                pop  = !head_trap_q && head_v_q;
                tgt  = head_q;
            end
            OP_BLK_DATA: ok = (pool_q[cur_idx] == P_ACTIVE);
            OP_BLK_STRUCT: begin
                ok  = (pool_q[cur_idx] == P_ACTIVE);
                app = 1'b1;
            end
            OP_WAKE: begin
                ok      = wk_found;
                app     = 1'b1;
                app_idx = wk_idx;
                tgt     = wk_idx;
            end
            OP_SPILL: ok = (pool_q[cur_idx] != P_CACHE);
            OP_FREE:  ok = (pool_q[cur_idx] == P_ACTIVE);
        endcase
    end

    // ---------------- state register ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (op_valid && cache_busy) state_d = S_HOLD;
            S_HOLD: if (!cache_busy)            state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- control state ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q     <= '0;
            nxt_v_q     <= '0;
            trp_q       <= '0;
            head_q      <= '0;
            tail_q      <= '0;
            head_v_q    <= 1'b0;
            head_trap_q <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) pool_q[i] <= P_CACHE;
        end else begin
            if (fill_en && pool_q[fill_idx] == P_CACHE) valid_q[fill_idx] <= 1'b1;
            if (exec && ok) begin
                if (pop) begin
                    head_q         <= nxt_q[head_q];
                    head_v_q       <= nxt_v_q[head_q];
                    head_trap_q    <= trp_q[head_q];
                    pool_q[head_q] <= P_ACTIVE;
                end
                if (trap) head_trap_q <= 1'b0;
                if (app) begin
                    if (!head_v_q) begin
                        head_q   <= app_idx;
                        head_v_q <= 1'b1;
                    end else begin
                        nxt_v_q[tail_q] <= 1'b1;
                    end
                    tail_q          <= app_idx;
                    nxt_v_q[app_idx] <= 1'b0;
                    trp_q[app_idx]   <= 1'b0;
                    pool_q[app_idx]  <= P_READY;
                end
                unique case (cur_op)
                    OP_SPAWN:    valid_q[cur_idx] <= 1'b0;
                    OP_BLK_DATA: pool_q[cur_idx]  <= P_STALL;
                    OP_SPILL:    trp_q[cur_idx]   <= 1'b1;
                    OP_FREE: begin
                        pool_q[cur_idx]  <= P_CACHE;
                        valid_q[cur_idx] <= 1'b0;
                    end
                    OP_NONE, OP_ISSUE, OP_BLK_STRUCT, OP_WAKE: ;
                endcase
            end
        end
    end

    // ---------------- entry payload and pending command ----------------
    always_ff @(posedge clk) begin
        if (fill_en && pool_q[fill_idx] == P_CACHE) begin
            tag_q[fill_idx]  <= fill_tag;
            line_q[fill_idx] <= fill_line;
        end
        if (state_q == S_IDLE && op_valid) begin
            pend_op   <= sil_op_e'(op_code);
            pend_idx  <= op_idx;
            pend_ctx  <= op_ctx;
            pend_qid  <= op_qid;
            pend_fin  <= op_finger;
            pend_line <= op_line;
        end
        if (exec && ok) begin
            if (app && head_v_q) nxt_q[tail_q] <= app_idx;
            unique case (cur_op)
                OP_SPAWN: begin
                    line_q[cur_idx] <= cur_line;
                    ctx_q[cur_idx]  <= cur_ctx;
                    fin_q[cur_idx]  <= cur_fin;
                end
                OP_BLK_DATA: begin
                    blk_q[cur_idx] <= cur_qid;
                    fin_q[cur_idx] <= cur_fin;
                end
                OP_BLK_STRUCT: fin_q[cur_idx] <= cur_fin;
                OP_NONE, OP_ISSUE, OP_WAKE, OP_SPILL, OP_FREE: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit     <= 1'b0;
            lk_idx     <= '0;
            lk_line    <= '0;
            rsp_valid  <= 1'b0;
            rsp_ok     <= 1'b0;
            rsp_trap   <= 1'b0;
            rsp_idx    <= '0;
            rsp_ctx    <= '0;
            rsp_finger <= '0;
            rsp_line   <= '0;
        end else begin
            lk_hit     <= lk_req && tm_hit;
            lk_idx     <= tm_idx;
            lk_line    <= tm_hit ? line_q[tm_idx] : '0;
            rsp_valid  <= exec;
            rsp_ok     <= exec && ok;
            rsp_trap   <= exec && ok && trap;
            rsp_idx    <= tgt;
            rsp_ctx    <= (exec && ok && pop) ? ctx_q[head_q]  : '0;
            rsp_finger <= (exec && ok && pop) ? fin_q[head_q]  : '0;
            rsp_line   <= (exec && ok && pop) ? line_q[head_q] : '0;
        end
    end

    // ---------------- assertions ----------------
    // R11
    cache_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && op_valid && cache_busy) |=> !rsp_valid);

    // R11
    hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && !cache_busy) |=> rsp_valid);

    // R5
    head_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_v_q |-> (pool_q[head_q] == P_READY));

    // R5
    empty_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !head_v_q |-> ($countones(ready_mask) == 0));

    // R2
    hit_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (pool_q[lk_idx] == P_CACHE));

    // R9
    trap_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_ok && rsp_valid));

endmodule

// File: tb/sched_icache_array_test.sv
module sched_icache_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [11:0] lk_tag = '0;
    logic        lk_hit;
    logic [IW-1:0] lk_idx;
    logic [31:0] lk_line;
    logic        fill_en = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [11:0] fill_tag = '0;
    logic [31:0] fill_line = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [IW-1:0] op_idx = '0;
    logic [5:0]  op_ctx = '0;
    logic [3:0]  op_qid = '0;
    logic [2:0]  op_finger = '0;
    logic [31:0] op_line = '0;
    logic        op_ready, rsp_valid, rsp_ok, rsp_trap;
    logic [IW-1:0] rsp_idx;
    logic [5:0]  rsp_ctx;
    logic [2:0]  rsp_finger;
    logic [31:0] rsp_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    sched_icache_array uut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_line(lk_line),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_line(fill_line),
        .op_valid(op_valid), .op_code(op_code), .op_idx(op_idx), .op_ctx(op_ctx),
        .op_qid(op_qid), .op_finger(op_finger), .op_line(op_line), .op_ready(op_ready),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_trap(rsp_trap), .rsp_idx(rsp_idx),
        .rsp_ctx(rsp_ctx), .rsp_finger(rsp_finger), .rsp_line(rsp_line)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model: pool 0 cache, 1 ready, 2 active, 3 stalled
    bit        mvalid [N];
    int        mpool  [N];
    bit [11:0] mtag   [N];
    bit [31:0] mline  [N];
    bit [5:0]  mctx   [N];
    bit [2:0]  mfin   [N];
    bit [3:0]  mblk   [N];
    bit        mtrp   [N];
    int        rq[$];
    bit        mtrap_pend;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_lookup(input bit [11:0] t, output bit hit, output int idx);
        hit = 0; idx = 0;
        for (int i = N - 1; i >= 0; i--)
            if (mvalid[i] && mpool[i] == 0 && mtag[i] == t) begin hit = 1; idx = i; end
    endfunction

    function automatic void model_append(input int x);
        mpool[x] = 1; mtrp[x] = 0; rq.push_back(x);
    endfunction

    function automatic void model_exec(input int op, input int idx, input bit [5:0] c, input bit [3:0] q,
                                       input bit [2:0] f, input bit [31:0] l,
                                       output bit eok, output bit etrap, output int eidx,
                                       output bit [5:0] ectx, output bit [2:0] efin, output bit [31:0] eline);
        eok = 0; etrap = 0; eidx = idx; ectx = 0; efin = 0; eline = 0;
        case (op)
            1: if (mpool[idx] == 0) begin
                eok = 1; mvalid[idx] = 0; mctx[idx] = c; mfin[idx] = f; mline[idx] = l; model_append(idx);
            end
            2: if (mtrap_pend) begin
                eok = 1; etrap = 1; mtrap_pend = 0;
            end else if (rq.size() > 0) begin
                int x;
                x = rq.pop_front();
                eok = 1; eidx = x; ectx = mctx[x]; efin = mfin[x]; eline = mline[x];
                mpool[x] = 2; mtrap_pend = mtrp[x];
            end
            3: if (mpool[idx] == 2) begin
                eok = 1; mpool[idx] = 3; mblk[idx] = q; mfin[idx] = f;
            end
            4: if (mpool[idx] == 2) begin
                eok = 1; mfin[idx] = f; model_append(idx);
            end
            5: begin
                int w;
                w = -1;
                for (int i = N - 1; i >= 0; i--)
                    if (mpool[i] == 3 && mctx[i] == c && mblk[i] == q) w = i;
                if (w >= 0) begin eok = 1; eidx = w; model_append(w); end
            end
            6: if (mpool[idx] != 0) begin eok = 1; mtrp[idx] = 1; end
            7: if (mpool[idx] == 2) begin eok = 1; mpool[idx] = 0; mvalid[idx] = 0; end
            default: ;
        endcase
    endfunction

    task automatic do_fill(input int idx, input bit [11:0] t, input bit [31:0] l);
        @(negedge clk);
        fill_en = 1; fill_idx = IW'(idx); fill_tag = t; fill_line = l;
        @(negedge clk);
        fill_en = 0;
        if (mpool[idx] == 0) begin mvalid[idx] = 1; mtag[idx] = t; mline[idx] = l; end
    endtask

    task automatic do_lookup(input bit [11:0] t, input string req);
        bit eh; int ei;
        @(negedge clk);
        lk_req = 1; lk_tag = t;
        @(negedge clk);
        lk_req = 0;
        model_lookup(t, eh, ei);
        chk(req, "lookup hit", 64'(lk_hit), 64'(eh));
        if (eh) begin
            chk(req, "lookup idx", 64'(lk_idx), 64'(ei));
            chk(req, "lookup line", 64'(lk_line), 64'(mline[ei]));
        end
    endtask

    task automatic do_op(input int op, input int idx, input bit [5:0] c, input bit [3:0] q,
                         input bit [2:0] f, input bit [31:0] l, input bit conflict, input string req);
        bit eok, etrap; int eidx; bit [5:0] ectx; bit [2:0] efin; bit [31:0] eline;
        @(negedge clk);
        chk("R11", "op_ready before command", 64'(op_ready), 64'd1);
        op_valid = 1; op_code = 3'(op); op_idx = IW'(idx); op_ctx = c; op_qid = q;
        op_finger = f; op_line = l;
        if (conflict) begin lk_req = 1; lk_tag = 12'hFFF; end
        @(negedge clk);
        op_valid = 0; lk_req = 0;
        if (conflict) begin
            chk("R11", "response held back by cache access", 64'(rsp_valid), 64'd0);
            @(negedge clk);
        end
        model_exec(op, idx, c, q, f, l, eok, etrap, eidx, ectx, efin, eline);
        chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(req, "rsp_ok", 64'(rsp_ok), 64'(eok));
        chk(req, "rsp_trap", 64'(rsp_trap), 64'(etrap));
        if (eok && !etrap) chk(req, "rsp_idx", 64'(rsp_idx), 64'(eidx));
        if (op == 2 && eok && !etrap) begin
            chk(req, "rsp_ctx", 64'(rsp_ctx), 64'(ectx));
            chk(req, "rsp_finger", 64'(rsp_finger), 64'(efin));
            chk(req, "rsp_line", 64'(rsp_line), 64'(eline));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            mvalid[i] = 0; mpool[i] = 0; mtrp[i] = 0; mtag[i] = 0; mline[i] = 0;
            mctx[i] = 0; mfin[i] = 0; mblk[i] = 0;
        end
        mtrap_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1", "op_ready after reset", 64'(op_ready), 64'd1);
        do_lookup(12'h000, "R1");
        do_op(2, 0, 0, 0, 0, 0, 0, "R1");

        // R2 R3 fills and lookups
        for (int i = 0; i < N; i++) do_fill(i, 12'h100 + 12'(i), 32'hA000_0000 + 32'(i));
        do_lookup(12'h103, "R2");
        do_fill(6, 12'h101, 32'h6666_6666);
        do_lookup(12'h101, "R2");
        do_lookup(12'h1F0, "R2");

        // R4 spawn reclaims a cache line
        do_op(1, 2, 6'd5, 0, 3'd3, 32'hC0DE_0002, 0, "R4");
        do_lookup(12'h102, "R4");
        do_op(1, 2, 6'd7, 0, 3'd1, 32'h0, 0, "R4");
        do_fill(2, 12'h1AA, 32'hDEAD_BEEF);
        do_lookup(12'h1AA, "R3");

        // R5 R6 R7 R8 list behaviour
        do_op(1, 4, 6'd1, 0, 3'd2, 32'hC0DE_0004, 0, "R5");
        do_op(1, 5, 6'd2, 0, 3'd4, 32'hC0DE_0005, 0, "R5");
        do_op(2, 0, 0, 0, 0, 0, 0, "R5");
        do_op(2, 0, 0, 0, 0, 0, 0, "R5");
        do_op(4, 2, 0, 0, 3'd6, 0, 0, "R7");
        do_op(2, 0, 0, 0, 0, 0, 0, "R5");
        do_op(2, 0, 0, 0, 0, 0, 0, "R7");
        do_op(3, 2, 0, 4'd9, 3'd7, 0, 0, "R6");
        do_op(3, 4, 0, 4'd3, 3'd5, 0, 0, "R6");
        do_op(2, 0, 0, 0, 0, 0, 0, "R6");
        do_op(5, 0, 6'd5, 4'd8, 0, 0, 0, "R8");
        do_op(5, 0, 6'd5, 4'd9, 0, 0, 0, "R8");
        do_op(2, 0, 0, 0, 0, 0, 0, "R8");

        // R9 spill mark
        do_op(5, 0, 6'd1, 4'd3, 0, 0, 0, "R8");
        do_op(1, 0, 6'd9, 0, 3'd1, 32'hC0DE_0000, 0, "R9");
        do_op(6, 4, 0, 0, 0, 0, 0, "R9");
        do_op(2, 0, 0, 0, 0, 0, 0, "R9");
        do_op(2, 0, 0, 0, 0, 0, 0, "R9");
        do_op(2, 0, 0, 0, 0, 0, 0, "R9");

        // R10 R12 free and wrong-pool commands
        do_op(7, 4, 0, 0, 0, 0, 0, "R10");
        do_lookup(12'h104, "R10");
        do_fill(4, 12'h1BB, 32'h4444_BBBB);
        do_lookup(12'h1BB, "R10");
        do_op(7, 4, 0, 0, 0, 0, 0, "R12");
        do_op(3, 6, 0, 4'd1, 0, 0, 0, "R12");
        do_op(0, 1, 0, 0, 0, 0, 0, "R12");
        do_lookup(12'h106, "R12");

        // R11 collision with cache port
        do_op(4, 0, 0, 0, 3'd2, 0, 1, "R11");
        do_op(2, 0, 0, 0, 0, 0, 1, "R11");

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            r = $urandom % 10;
            if (r < 2) begin
                do_fill($urandom % N, 12'h100 + 12'($urandom % 16), $urandom);
            end else if (r < 4) begin
                do_lookup(12'h100 + 12'($urandom % 16), "R2");
            end else begin
                int op; int idx; bit [5:0] c; bit [3:0] q;
                op = 1 + ($urandom % 7);
                idx = $urandom % N;
                c = 6'($urandom % 4);
                q = 4'($urandom % 4);
                if (op == 5 && ($urandom % 2) == 1) begin
                    for (int i = 0; i < N; i++)
                        if (mpool[i] == 3) begin c = mctx[i]; q = mblk[i]; end
                end
                do_op(op, idx, c, q, 3'($urandom), $urandom, ($urandom % 4) == 0,
                      op == 1 ? "R4" : op == 2 ? "R5" : op == 3 ? "R6" : op == 4 ? "R7" :
                      op == 5 ? "R8" : op == 6 ? "R9" : "R10");
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule